// File: doc/BRIEF.md
# SPI Master with Control Register

This block is a byte-oriented serial peripheral master run by a single control register. Software sets the clock polarity, clock phase, master selection, system enable and an internal loopback path through a synchronous register port. It queues outgoing bytes in a transmit FIFO and collects incoming bytes from a receive FIFO. When the engine is enabled in master mode and the transmit FIFO holds data, it starts a transfer on its own. Each transfer lowers the single active-low select, shifts eight bits MSB first over SCK/MOSI/MISO and stores the byte it captured.

The control register also carries a self-clearing bit that discards everything waiting in the transmit FIFO. In loopback mode the engine's own serial output is fed back to its receiver, the MISO pin is ignored and the external device is never selected. SCK runs at the system clock divided by `2*CLK_DIV`. Mode 3 (polarity 1, phase 1) drives data on the falling edge and samples it on the rising edge, and the other three modes are also supported.

Top module: `spi_ctl_master`

## Requirements
- R1: After reset every control bit reads 0, `ss_n` is 1, `sck` is 0 and `rx_data` is 0.
- R2: Control fields sit at bit 0 loopback, bit 1 enable, bit 2 master, bit 3 polarity, bit 4 phase and bit 5 transmit-FIFO flush. Bits 0 to 4 read back exactly as last written.
- R3: Writing 1 to bit 5 makes it read 1 in the following cycle and 0 one cycle after that with no further write. All bytes queued before the flush are discarded and never transmitted.
- R4: Whenever no transfer is in progress, `sck` equals the polarity bit (0 idles low, 1 idles high).
- R5: With phase 0, MOSI is valid from the moment of select and both sides sample on the leading SCK edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge. Each transfer has exactly 8 SCK pulses, MSB first, and in mode 3 data is driven on the falling edge and sampled on the rising edge.
- R6: No transfer starts while the master bit is 0, even with enable set and data queued.
- R7: No transfer starts while the enable bit is 0. Bytes queued meanwhile go out once enable and master are both set.
- R8: While enable and master are 1, transfers start by themselves as long as the transmit FIFO is non-empty. `ss_n` stays low for the whole byte, and the byte sampled from MISO is placed in the receive FIFO.
- R9: In loopback mode the receive FIFO gets the engine's own transmitted byte, MISO has no effect, and `ss_n` stays 1.
- R10: The transmit FIFO holds 16 bytes, and a write to a full transmit FIFO is dropped.
- R11: Reading an empty receive FIFO returns 0. A byte that completes while the 16-entry receive FIFO is full is dropped and the older contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control register write value |
| ctrl_rdata | output | 6 | Control register current value |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO, 0 when empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The hardest case to reach is the receive FIFO overflowing while the transmit FIFO is also at capacity. It needs seventeen queued writes, sixteen completed transfers with nothing read back, and then one more transfer. The bench builds this while enable is off: it fills the transmit queue past its limit, switches on loopback and enable so every byte comes back as a known value, and sends one extra byte once the receive FIFO is full. A bench-side slave model follows all four polarity and phase combinations by watching SCK transitions, so both MOSI capture and MISO launch are checked in each mode.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef struct packed {
    logic txflush;
    logic phase;
    logic polarity;
    logic master;
    logic enable;
    logic loopback;
  } spim_ctrl_t;

  localparam int CTRL_W = $bits(spim_ctrl_t);

  // An edge index is odd for a leading edge. Phase 0 samples on the leading
  // edge and phase 1 samples on the trailing edge.
  function automatic logic is_sample_edge(input logic edge_lsb, input logic phase);
    return edge_lsb ^ phase;
  endfunction

  // Index of the edge that carries the last data bit's sample.
  function automatic int last_sample_edge(input int data_w, input logic phase);
    return phase ? 2 * data_w : 2 * data_w - 1;
  endfunction

  function automatic int fifo_next_ptr(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  import spim_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(fifo_next_ptr(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(fifo_next_ptr(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spim_ctrl_reg.sv
module spim_ctrl_reg
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output spim_ctrl_t        ctrl,
  output logic [CTRL_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr) begin
      ctrl <= spim_ctrl_t'(wdata);
    end else begin
      ctrl.txflush <= 1'b0;
    end
  end

  assign rdata = CTRL_W'(ctrl);
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 2,
  localparam int EW     = $clog2(2 * DATA_W + 2),
  localparam int DW     = $clog2(CLK_DIV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              polarity,
  input  logic              phase,
  input  logic              loopback,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spim_pkg::*;

  localparam int LAST_EDGE = 2 * DATA_W;
  localparam int END_TICK  = 2 * DATA_W + 1;

  logic [DW-1:0]     div_cnt;
  logic [EW-1:0]     edge_cnt, edge_n;
  logic              sck_int, mosi_q, ser_in;
  logic [DATA_W-1:0] txs;
  logic [DATA_W-2:0] rxs;
  logic              start, tick, last_tick, sample_evt, shift_evt;

  assign start      = !busy && run_ok && tx_avail;
  assign tick       = busy && (div_cnt == DW'(CLK_DIV - 1));
  assign edge_n     = edge_cnt + 1'b1;
  assign last_tick  = tick && (edge_n == EW'(END_TICK));
  assign sample_evt = tick && !last_tick && is_sample_edge(edge_n[0], phase);
  assign shift_evt  = tick && (edge_n < EW'(LAST_EDGE)) && !is_sample_edge(edge_n[0], phase);
  assign ser_in     = loopback ? mosi_q : miso;
  assign rx_byte    = {rxs, ser_in};
  assign rx_push    = sample_evt && (edge_n == EW'(last_sample_edge(DATA_W, phase)));
  assign tx_pop     = start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sck_int  <= 1'b0;
      mosi_q   <= 1'b0;
      txs      <= '0;
      rxs      <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        div_cnt  <= '0;
        edge_cnt <= '0;
        sck_int  <= 1'b0;
        if (phase) begin
          txs    <= tx_byte;
          mosi_q <= 1'b0;
        end else begin
          txs    <= tx_byte << 1;
          mosi_q <= tx_byte[DATA_W-1];
        end
      end
    end else if (tick) begin
      div_cnt  <= '0;
      edge_cnt <= edge_n;
      if (last_tick) begin
        busy <= 1'b0;
      end else begin
        sck_int <= ~sck_int;
        if (sample_evt) rxs <= rx_byte[DATA_W-2:0];
        if (shift_evt) begin
          mosi_q <= txs[DATA_W-1];
          txs    <= txs << 1;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign sck  = sck_int ^ polarity;
  assign mosi = mosi_q;
  assign ss_n = !(busy && !loopback);
endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_DIV    = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [5:0]        ctrl_wdata,
  output logic [5:0]        ctrl_rdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spim_pkg::*;

  spim_ctrl_t        ctrl;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
  logic              xfer_start, rx_push, eng_busy, run_ok, tx_avail;

  spim_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .wdata (ctrl_wdata),
    .ctrl  (ctrl),
    .rdata (ctrl_rdata)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctrl.txflush),
    .push  (tx_wr),
    .din   (tx_data),
    .pop   (xfer_start),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full),
    .count (tx_count)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (1'b0),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rx_rd),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .count (rx_count)
  );

  assign run_ok   = ctrl.enable && ctrl.master;
  assign tx_avail = !tx_empty && !ctrl.txflush;

  spim_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_ok   (run_ok),
    .polarity (ctrl.polarity),
    .phase    (ctrl.phase),
    .loopback (ctrl.loopback),
    .tx_avail (tx_avail),
    .tx_byte  (tx_head),
    .tx_pop   (xfer_start),
    .rx_push  (rx_push),
    .rx_byte  (rx_byte),
    .busy     (eng_busy),
    .sck      (sck),
    .mosi     (mosi),
    .miso     (miso),
    .ss_n     (ss_n)
  );

  assign rx_data = rx_empty ? '0 : rx_head;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       ctrl_rdata,
  input logic             sck,
  input logic             ss_n,
  input logic             busy,
  input logic             xfer_start,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             tx_full,
  input logic             rx_full,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count
);
  assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[5] |=> !ctrl_rdata[5]);

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[5] |=> (tx_count == '0));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == ctrl_rdata[3]));

  assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (ctrl_rdata[2] && ctrl_rdata[1]));

  assert_ss_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss_n);

  assert_loop_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[0] |-> ss_n);

  assert_tx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !xfer_start) |=> (tx_count == CNT_W'(DEPTH)) || $past(ctrl_rdata[5]) || ctrl_rdata[5]);

  assert_rx_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_pop) |=> (rx_count == CNT_W'(DEPTH)));
endmodule

bind spi_ctl_master spim_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rdata (ctrl_rdata),
  .sck        (sck),
  .ss_n       (ss_n),
  .busy       (eng_busy),
  .xfer_start (xfer_start),
  .rx_push    (rx_push),
  .rx_pop     (rx_rd),
  .tx_full    (tx_full),
  .rx_full    (rx_full),
  .tx_count   (tx_count),
  .rx_count   (rx_count)
);

// File: tb/spi_ctl_master_bench.sv
module spi_ctl_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [5:0] ctrl_rdata;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       sck, mosi, ss_n, miso;
  logic       slv_miso = 1'b0;
  logic       miso_one = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign miso = miso_one ? 1'b1 : slv_miso;

  spi_ctl_master u_spi_ctl_master (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bit fields: 0 loopback, 1 enable, 2 master, 3 polarity, 4 phase, 5 flush
  logic cfg_pol = 1'b0, cfg_pha = 1'b0;

  function automatic logic [7:0] slave_byte(input int n);
    return 8'((n * 29 + 90) & 255) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] host_byte(input int m, input int i);
    return 8'((37 * m + 11 * i + 3) & 255) ^ 8'hC3;
  endfunction

  // Bench-side slave model, polled between clock edges.
  int         frames = 0, k = 0, edges = 0;
  logic [7:0] stx = '0, srx = '0;
  logic [7:0] slv_got [0:63];
  logic       prev_ss = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss && !ss_n) begin
        stx = slave_byte(frames);
        frames++;
        k = 0; srx = '0; edges = 0;
        if (!cfg_pha) slv_miso = stx[7];
      end else if (!ss_n && sck != prev_sck) begin
        edges++;
        if ((sck == 1'b1) == (cfg_pol == cfg_pha)) begin
          srx = {srx[6:0], mosi};
        end else if (cfg_pha) begin
          slv_miso = stx[3'(7 - k)];
          k++;
        end else begin
          k++;
          if (k < 8) slv_miso = stx[3'(7 - k)];
        end
      end else if (!prev_ss && ss_n) begin
        slv_got[frames - 1] = srx;
        chk(edges == 16, "R5 sck edges per frame", edges, 16);
      end
    end
    prev_ss = ss_n;
    prev_sck = sck;
  end

  task automatic ctrl_write(input logic [5:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    cfg_pol = v[3]; cfg_pha = v[4];
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); tx_wr = 1'b1; tx_data = v;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop(output logic [7:0] v);
    @(negedge clk); v = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 6'd0, "R1 ctrl", ctrl_rdata, 0);
    chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_data == 8'd0, "R1 rx_data", rx_data, 0);

    // R2 readback sweep of bits 0..4 (transmit FIFO empty so nothing moves)
    for (int i = 0; i < 32; i++) begin
      ctrl_write(6'(i));
      chk(ctrl_rdata == 6'(i), "R2 readback", ctrl_rdata, i);
      // R4 idle level follows polarity
      chk(sck == 1'(i >> 3), "R4 sck idle", sck, (i >> 3) & 1);
    end
    chk(frames == 0, "R2 no frames", frames, 0);

    // R5 R8 all four modes against the slave model
    for (int m = 0; m < 4; m++) begin
      ctrl_write(6'b000110 | 6'((m & 1) << 3) | 6'(((m >> 1) & 1) << 4));
      base = frames;
      for (int i = 0; i < 4; i++) push(host_byte(m, i));
      idle(4 * 40 + 10);
      chk(frames == base + 4, "R8 frame count", frames, base + 4);
      chk(sck == 1'(m & 1), "R4 idle after frames", sck, m & 1);
      for (int i = 0; i < 4; i++) begin
        chk(slv_got[base + i] == host_byte(m, i), "R5 mosi byte", slv_got[base + i], host_byte(m, i));
        pop(v);
        chk(v == slave_byte(base + i), "R8 miso byte", v, slave_byte(base + i));
      end
      pop(v);
      chk(v == 8'd0, "R11 empty read", v, 0);
    end

    // R6 master bit low: nothing moves
    ctrl_write(6'b011010);
    base = frames;
    push(8'h5A);
    idle(100);
    chk(frames == base, "R6 no transfer", frames, base);
    chk(rx_data == 8'd0, "R6 rx empty", rx_data, 0);
    ctrl_write(6'b011110);
    idle(50);
    chk(frames == base + 1, "R6 transfer after master", frames, base + 1);
    chk(slv_got[base] == 8'h5A, "R6 byte", slv_got[base], 8'h5A);
    pop(v);

    // R7 enable low: queued byte waits
    ctrl_write(6'b011100);
    base = frames;
    push(8'hA7);
    idle(100);
    chk(frames == base, "R7 no transfer", frames, base);
    ctrl_write(6'b011110);
    idle(50);
    chk(frames == base + 1, "R7 transfer after enable", frames, base + 1);
    chk(slv_got[base] == 8'hA7, "R7 byte", slv_got[base], 8'hA7);
    pop(v);

    // R3 flush discards queued bytes
    ctrl_write(6'b011100);
    base = frames;
    push(8'h11); push(8'h22); push(8'h33);
    ctrl_write(6'b111100);
    chk(ctrl_rdata[5] == 1'b1, "R3 flush bit set", ctrl_rdata[5], 1);
    @(negedge clk);
    chk(ctrl_rdata[5] == 1'b0, "R3 flush bit clear", ctrl_rdata[5], 0);
    ctrl_write(6'b011110);
    idle(150);
    chk(frames == base, "R3 flushed bytes not sent", frames, base);
    chk(rx_data == 8'd0, "R3 rx empty", rx_data, 0);
    push(8'h6C);
    idle(50);
    chk(frames == base + 1, "R3 later byte sent", frames, base + 1);
    chk(slv_got[base] == 8'h6C, "R3 later byte", slv_got[base], 8'h6C);
    pop(v);

    // R9 loopback ignores miso, never selects; R10 R11 overflow both FIFOs
    miso_one = 1'b1;
    ctrl_write(6'b011101);
    base = frames;
    for (int i = 0; i < 17; i++) push(8'(i * 13 + 2) & 8'h7E);
    ctrl_write(6'b011111);
    idle(17 * 40 + 20);
    push(8'hEE);
    idle(60);
    chk(frames == base, "R9 ss_n never low", frames, base);
    for (int i = 0; i < 16; i++) begin
      pop(v);
      chk(v == (8'(i * 13 + 2) & 8'h7E), "R9 R10 loopback byte", v, 8'(i * 13 + 2) & 8'h7E);
    end
    pop(v);
    chk(v == 8'd0, "R10 R11 dropped bytes absent", v, 0);
    miso_one = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule